// File: doc/BRIEF.md
# Dual-pixel raster timing generator

This block produces the raster timing for a 1400 x 1050 flat panel that receives two pixels on every data clock: an even pixel and the odd pixel to its right. It runs on the panel data clock. It drives a horizontal sync, a vertical sync, a display-enable strobe, the horizontal position counted in pixel pairs and the vertical position counted in lines. It also drives a pair column, which is the column of the even pixel of the current pair. Upstream fetch logic uses that column to read both pixels of the pair at the same time.

Because one horizontal count covers one pixel pair, the default active width is 700 clocks for 1400 pixels. Each line runs in this order: active pairs, front porch, sync pulse, back porch. Each frame runs in the same order, counted in lines. The default line is 844 clocks and the default frame is 1066 lines, which gives a frame rate close to 60 Hz at a 54 MHz data clock. A level input selects the polarity of each sync. The sum of active width and back porch must stay below a configurable clock limit, and the block refuses to elaborate with any configuration that breaks this rule. All outputs are registered. A synchronous reset places the raster at the first active pair of the first line.

Top module: `dual_pixel_raster_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs after that edge show the first active pair: `hcount`=0, `vcount`=0, `de`=1, `pair_col`=0, and both syncs at their inactive level.
- R2: With `rst` low, `hcount` rises by one on each clock. After it reaches H_TOTAL-1 it returns to 0, where H_TOTAL = H_ACTIVE+H_FRONT+H_SYNC+H_BACK.
- R3: `vcount` rises by one only on the clock where `hcount` wraps. After it reaches V_TOTAL-1 it returns to 0, where V_TOTAL = V_ACTIVE+V_FRONT+V_SYNC+V_BACK.
- R4: `de` is 1 exactly when `hcount` < H_ACTIVE and `vcount` < V_ACTIVE.
- R5: The horizontal sync is at its active level exactly when `hcount` lies in [H_ACTIVE+H_FRONT, H_ACTIVE+H_FRONT+H_SYNC). A line therefore runs active, front porch, sync, back porch.
- R6: The vertical sync is at its active level for whole lines, exactly when `vcount` lies in [V_ACTIVE+V_FRONT, V_ACTIVE+V_FRONT+V_SYNC).
- R7: A polarity input of 1 makes its sync active-high and a value of 0 makes it active-low. The value present at a clock edge sets the level of the outputs registered at that edge.
- R8: While `de` is 1, `pair_col` equals 2*`hcount`, which is the even pixel of the pair. The odd pixel of the same pair is `pair_col`+1. While `de` is 0, `pair_col` is 0.
- R9: The default parameters give a line of 844 clocks, with the horizontal sync at counts 724 to 779 inclusive and `de` high for counts 0 to 699. They give a frame of 1066 lines.
- R10: The configuration rule `raster_pkg::cfg_legal(active, back, limit)` returns 1 when active+back < limit and 0 otherwise. The top refuses to elaborate when it returns 0 for H_ACTIVE, H_BACK and HAB_LIMIT (default 1024).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Panel data clock, one pixel pair per cycle |
| rst | input | 1 | Synchronous reset, active high |
| hsync_pol | input | 1 | Horizontal sync polarity: 1 active-high, 0 active-low |
| vsync_pol | input | 1 | Vertical sync polarity: 1 active-high, 0 active-low |
| hsync | output | 1 | Horizontal sync, registered |
| vsync | output | 1 | Vertical sync, registered |
| de | output | 1 | Display enable, high while pair data is to be shown |
| hcount | output | HW = clog2(H_TOTAL) | Horizontal position in pixel pairs |
| vcount | output | VW = clog2(V_TOTAL) | Vertical position in lines |
| pair_col | output | CW = clog2(2*H_ACTIVE) | Column of the even pixel of the current pair |

## Verification
The assertions take `rst` to be synchronous and take the polarity inputs to be free to change on any cycle. The sync checks therefore compare each output against the polarity value from the previous edge rather than the current one. They also take the parameters to satisfy the configuration rule and to give non-zero active sizes, so that reset can land on an active pair. The stimulus changes the polarity inputs and pulses reset only on falling clock edges, and it keeps every parameter set legal. It uses a small raster so that many full frames and wraps fit in one run, and it also exercises the default 844-clock line in a second instance.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // Phase of one raster axis; a line or a frame runs through them in this order.
    typedef enum logic [1:0] {
        PH_ACTIVE,
        PH_FRONT,
        PH_SYNC,
        PH_BACK
    } phase_e;

    // Active plus back porch must stay strictly below the limit.
    function automatic bit cfg_legal(input int active, input int back, input int limit);
        return (active + back) < limit;
    endfunction

endpackage

// File: rtl/raster_axis.sv
// One raster axis: next count and phase decode of that next count.
module raster_axis
    import raster_pkg::*;
#(
    parameter int ACTIVE = 8,
    parameter int FRONT  = 1,
    parameter int SYNC   = 1,
    parameter int BACK   = 1,
    parameter int W      = 4
) (
    input  logic [W-1:0] cur,
    input  logic         adv,
    output logic [W-1:0] nxt,
    output logic         last,
    output phase_e       nxt_phase
);

    localparam int TOTAL = ACTIVE + FRONT + SYNC + BACK;
    localparam logic [W-1:0] C_LAST     = W'(TOTAL - 1);
    localparam logic [W-1:0] C_FRONT_AT = W'(ACTIVE);
    localparam logic [W-1:0] C_SYNC_AT  = W'(ACTIVE + FRONT);
    localparam logic [W-1:0] C_BACK_AT  = W'(ACTIVE + FRONT + SYNC);

    always_comb begin
        last = (cur == C_LAST);
        if (!adv) begin
            nxt = cur;
        end else if (last) begin
            nxt = '0;
        end else begin
            nxt = cur + 1'b1;
        end

        if (nxt < C_FRONT_AT) begin
            nxt_phase = PH_ACTIVE;
        end else if (nxt < C_SYNC_AT) begin
            nxt_phase = PH_FRONT;
        end else if (nxt < C_BACK_AT) begin
            nxt_phase = PH_SYNC;
        end else begin
            nxt_phase = PH_BACK;
        end
    end

endmodule

// File: rtl/raster_pair_map.sv
// Maps a pair position to the column of its even pixel.
module raster_pair_map #(
    parameter int HW = 5,
    parameter int CW = 4
) (
    input  logic [HW-1:0] pair_pos,
    input  logic          active,
    output logic [CW-1:0] even_col
);

    always_comb begin
        if (active) begin
            even_col = CW'({pair_pos, 1'b0});
        end else begin
            even_col = '0;
        end
    end

endmodule

// File: rtl/dual_pixel_raster_gen.sv
module dual_pixel_raster_gen
    import raster_pkg::*;
#(
    parameter int H_ACTIVE  = 700,
    parameter int H_FRONT   = 24,
    parameter int H_SYNC    = 56,
    parameter int H_BACK    = 64,
    parameter int V_ACTIVE  = 1050,
    parameter int V_FRONT   = 1,
    parameter int V_SYNC    = 3,
    parameter int V_BACK    = 12,
    parameter int HAB_LIMIT = 1024,
    localparam int H_TOTAL  = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
    localparam int V_TOTAL  = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
    localparam int HW       = $clog2(H_TOTAL),
    localparam int VW       = $clog2(V_TOTAL),
    localparam int CW       = $clog2(2 * H_ACTIVE)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hsync_pol,
    input  logic          vsync_pol,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [HW-1:0] hcount,
    output logic [VW-1:0] vcount,
    output logic [CW-1:0] pair_col
);

    // Configuration rule on active width plus back porch (R10).
    if (!cfg_legal(H_ACTIVE, H_BACK, HAB_LIMIT)) begin : g_cfg_bad
        $error("raster config: H_ACTIVE + H_BACK must be below HAB_LIMIT");
    end

    localparam logic [HW-1:0] H_LAST_C  = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] H_ACT_C   = HW'(H_ACTIVE);
    localparam logic [HW-1:0] H_SYS_C   = HW'(H_ACTIVE + H_FRONT);
    localparam logic [HW-1:0] H_SYE_C   = HW'(H_ACTIVE + H_FRONT + H_SYNC);
    localparam logic [VW-1:0] V_LAST_C  = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0] V_ACT_C   = VW'(V_ACTIVE);
    localparam logic [VW-1:0] V_SYS_C   = VW'(V_ACTIVE + V_FRONT);
    localparam logic [VW-1:0] V_SYE_C   = VW'(V_ACTIVE + V_FRONT + V_SYNC);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
        logic          de;
        logic          hs;
        logic          vs;
        logic [CW-1:0] col;
    } raster_t;

    raster_t st_d, st_q;

    logic [HW-1:0] h_nxt_d;
    logic [VW-1:0] v_nxt_d;
    logic          h_last_d;
    logic          v_last_d;
    phase_e        h_phase_d;
    phase_e        v_phase_d;
    logic          act_d;
    logic [CW-1:0] col_d;

    raster_axis #(
        .ACTIVE (H_ACTIVE),
        .FRONT  (H_FRONT),
        .SYNC   (H_SYNC),
        .BACK   (H_BACK),
        .W      (HW)
    ) h_axis_i (
        .cur       (st_q.h),
        .adv       (1'b1),
        .nxt       (h_nxt_d),
        .last      (h_last_d),
        .nxt_phase (h_phase_d)
    );

    raster_axis #(
        .ACTIVE (V_ACTIVE),
        .FRONT  (V_FRONT),
        .SYNC   (V_SYNC),
        .BACK   (V_BACK),
        .W      (VW)
    ) v_axis_i (
        .cur       (st_q.v),
        .adv       (h_last_d),
        .nxt       (v_nxt_d),
        .last      (v_last_d),
        .nxt_phase (v_phase_d)
    );

    assign act_d = (h_phase_d == PH_ACTIVE) && (v_phase_d == PH_ACTIVE);

    raster_pair_map #(
        .HW (HW),
        .CW (CW)
    ) pair_map_i (
        .pair_pos (h_nxt_d),
        .active   (act_d),
        .even_col (col_d)
    );

    always_comb begin
        if (rst) begin
            st_d.h   = '0;
            st_d.v   = '0;
            st_d.de  = 1'b1;
            st_d.hs  = ~hsync_pol;
            st_d.vs  = ~vsync_pol;
            st_d.col = '0;
        end else begin
            st_d.h   = h_nxt_d;
            st_d.v   = v_nxt_d;
            st_d.de  = act_d;
            st_d.hs  = (h_phase_d == PH_SYNC) ? hsync_pol : ~hsync_pol;
            st_d.vs  = (v_phase_d == PH_SYNC) ? vsync_pol : ~vsync_pol;
            st_d.col = col_d;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign hcount   = st_q.h;
    assign vcount   = st_q.v;
    assign de       = st_q.de;
    assign hsync    = st_q.hs;
    assign vsync    = st_q.vs;
    assign pair_col = st_q.col;

    // ---------------- assertions ----------------
    assert_h_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (hcount == H_LAST_C) |=> (hcount == '0));

    assert_h_step_R2: assert property (@(posedge clk) disable iff (rst)
        (hcount != H_LAST_C) |=> (hcount == $past(hcount) + 1'b1));

    assert_v_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (hcount != H_LAST_C) |=> $stable(vcount));

    assert_v_step_R3: assert property (@(posedge clk) disable iff (rst)
        (hcount == H_LAST_C && vcount != V_LAST_C) |=> (vcount == $past(vcount) + 1'b1));

    assert_v_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (hcount == H_LAST_C && vcount == V_LAST_C) |=> (vcount == '0));

    assert_de_window_R4: assert property (@(posedge clk) disable iff (rst)
        de == ((hcount < H_ACT_C) && (vcount < V_ACT_C)));

    assert_hsync_level_R5: assert property (@(posedge clk) disable iff (rst)
        ##1 (hsync == (((hcount >= H_SYS_C) && (hcount < H_SYE_C)) ?
                       $past(hsync_pol) : !$past(hsync_pol))));

    assert_vsync_level_R6: assert property (@(posedge clk) disable iff (rst)
        ##1 (vsync == (((vcount >= V_SYS_C) && (vcount < V_SYE_C)) ?
                       $past(vsync_pol) : !$past(vsync_pol))));

    assert_pair_col_R8: assert property (@(posedge clk) disable iff (rst)
        pair_col == (de ? CW'({hcount, 1'b0}) : CW'(0)));

endmodule

// File: tb/dual_pixel_raster_gen_tb_top.sv
module dual_pixel_raster_gen_tb_top;

    // Small raster for the main instance.
    localparam int HA = 8, HF = 2, HS = 3, HB = 4;
    localparam int VA = 5, VF = 1, VS = 2, VB = 2;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int HW = $clog2(HT);
    localparam int VW = $clog2(VT);
    localparam int CW = $clog2(2 * HA);

    // Default raster for the second instance.
    localparam int DHT = 844;
    localparam int DVT = 1066;
    localparam int DHW = $clog2(DHT);
    localparam int DVW = $clog2(DVT);
    localparam int DCW = $clog2(1400);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst2 = 1'b1;
    logic hpol = 1'b1;
    logic vpol = 1'b1;

    logic          hsync, vsync, de;
    logic [HW-1:0] hcount;
    logic [VW-1:0] vcount;
    logic [CW-1:0] pair_col;

    logic           d_hsync, d_vsync, d_de;
    logic [DHW-1:0] d_hcount;
    logic [DVW-1:0] d_vcount;
    logic [DCW-1:0] d_pair_col;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dual_pixel_raster_gen #(
        .H_ACTIVE (HA), .H_FRONT (HF), .H_SYNC (HS), .H_BACK (HB),
        .V_ACTIVE (VA), .V_FRONT (VF), .V_SYNC (VS), .V_BACK (VB)
    ) dut_i (
        .clk (clk), .rst (rst), .hsync_pol (hpol), .vsync_pol (vpol),
        .hsync (hsync), .vsync (vsync), .de (de),
        .hcount (hcount), .vcount (vcount), .pair_col (pair_col)
    );

    dual_pixel_raster_gen dut_dflt_i (
        .clk (clk), .rst (rst2), .hsync_pol (1'b1), .vsync_pol (1'b1),
        .hsync (d_hsync), .vsync (d_vsync), .de (d_de),
        .hcount (d_hcount), .vcount (d_vcount), .pair_col (d_pair_col)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int sync_level(input int pos, input int start, input int len, input bit pol);
        return ((pos >= start) && (pos < start + len)) ? int'(pol) : int'(!pol);
    endfunction

    // Reference position, updated at each rising edge from the inputs at that edge.
    int mh, mv, m2h, m2v;
    bit e_rst, e_hp, e_vp, e_rst2, valid;

    always @(posedge clk) begin
        if (rst) begin
            mh = 0; mv = 0;
        end else if (mh == HT - 1) begin
            mh = 0;
            mv = (mv == VT - 1) ? 0 : mv + 1;
        end else begin
            mh = mh + 1;
        end
        if (rst2) begin
            m2h = 0; m2v = 0;
        end else if (m2h == DHT - 1) begin
            m2h = 0;
            m2v = (m2v == DVT - 1) ? 0 : m2v + 1;
        end else begin
            m2h = m2h + 1;
        end
        e_rst = rst; e_rst2 = rst2; e_hp = hpol; e_vp = vpol;
        valid = 1'b1;
    end

    always @(negedge clk) begin
        if (valid && !finished) begin
            if (e_rst) begin
                chk("R1 hcount", int'(hcount), 0);
                chk("R1 vcount", int'(vcount), 0);
                chk("R1 de", int'(de), 1);
                chk("R1 pair_col", int'(pair_col), 0);
                chk("R1 R7 hsync", int'(hsync), int'(!e_hp));
                chk("R1 R7 vsync", int'(vsync), int'(!e_vp));
            end else begin
                chk("R2 hcount", int'(hcount), mh);
                chk("R3 vcount", int'(vcount), mv);
                chk("R4 de", int'(de), int'(mh < HA && mv < VA));
                chk("R5 R7 hsync", int'(hsync), sync_level(mh, HA + HF, HS, e_hp));
                chk("R6 R7 vsync", int'(vsync), sync_level(mv, VA + VF, VS, e_vp));
                chk("R8 pair_col", int'(pair_col), (mh < HA && mv < VA) ? 2 * mh : 0);
            end
            if (!e_rst2) begin
                chk("R9 hcount", int'(d_hcount), m2h);
                chk("R9 vcount", int'(d_vcount), m2v);
                chk("R9 de", int'(d_de), int'(m2h < 700 && m2v < 1050));
                chk("R9 hsync", int'(d_hsync), int'(m2h >= 724 && m2h <= 779));
            end
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        // Reset held for a few cycles (R1).
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rst2 = 1'b0;
        // Two full frames with active-high syncs (R2 to R6, R8).
        repeat (2 * HT * VT) @(negedge clk);
        // Two full frames with active-low syncs (R7).
        hpol = 1'b0;
        vpol = 1'b0;
        repeat (2 * HT * VT) @(negedge clk);
        // Reset mid-line, then back to the first active pair (R1).
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        // Random polarity flips and short reset pulses.
        for (int i = 0; i < 1500; i++) begin
            if ($urandom_range(19, 0) == 0) hpol = ~hpol;
            if ($urandom_range(19, 0) == 0) vpol = ~vpol;
            rst = ($urandom_range(299, 0) == 0);
            @(negedge clk);
        end
        rst = 1'b0;
        repeat (HT * VT) @(negedge clk);
        // Configuration rule (R10).
        chk("R10 legal default", int'(raster_pkg::cfg_legal(700, 64, 1024)), 1);
        chk("R10 edge 1023", int'(raster_pkg::cfg_legal(960, 63, 1024)), 1);
        chk("R10 edge 1024", int'(raster_pkg::cfg_legal(960, 64, 1024)), 0);
        finish_run();
    end

endmodule